// File: doc/BRIEF.md
# Module-Resident Error Correction Behind a Byte-Parity Host Port

This block lives on a memory module between a host controller that only knows byte parity and the storage array. Toward the host it behaves like an ordinary 36-bit parity memory: 32 data bits travel with 4 parity bits, one for each byte. Inside, every 32-bit word is kept as a 39-bit SEC-DED codeword. The codeword holds six Hamming check bits and one overall parity bit, all computed when the word is written.

On a write the incoming byte parity is checked and then dropped. A mismatch is remembered in a sticky flag, and the word is still stored with freshly computed check bits. On a read, any single flipped bit in the 39-bit codeword is repaired before the word leaves the module. Clean even parity is then rebuilt over the repaired data, so the host controller gains single-error correction without any change.

A double-bit error cannot be repaired. The module then drives deliberately wrong parity on every byte, so the host's own parity checker raises its error. A sideband status group shows the following:
- a saturating count of corrected reads;
- the address of the most recent failing read;
- the sticky write-parity flag.

A fault-injection mask on the write path models array defects for test.

Top module: `ecc_parity_module`

## Requirements
- R1: A read request (req_i=1, we_i=0) sampled at a rising edge makes rvalid_o high for exactly the following cycle, and rdata_o then carries the data last written to that address. A write request stores the word and drives rvalid_o low in the following cycle.
- R2: Whenever a read reports no double error, rpar_o[b] equals the XOR of rdata_o[8b+7:8b] (even parity per byte, b=0..3).
- R3: If exactly one bit of the stored 39-bit codeword is wrong, the read returns the originally written data and sec_o is high with rvalid_o. This holds for any of the 39 positions, including check bits. sec_o and ded_o are never high together, and neither is high without rvalid_o.
- R4: sec_cnt_o rises by one for each read with sec_o high, holds at all other times, and stays at 255 once it reaches 255.
- R5: err_addr_o takes the address of every read that reports sec_o or ded_o, and holds otherwise. Its reset value is 0.
- R6: If exactly two codeword bits are wrong, the read raises ded_o with rvalid_o and drives rpar_o[b] as the inverse of the XOR of rdata_o byte b, for every byte. sec_cnt_o does not change.
- R7: A write whose wpar_i[b] differs from the XOR of wdata_i byte b, for any b, sets wpar_err_o. The flag stays set until reset. The data is still stored and reads back correctly.
- R8: After reset all outputs are 0 and every address reads back data 0 with parity 0 and no error.
- R9: In cycles with no read, rvalid_o, sec_o and ded_o are low, and rdata_o and rpar_o keep the values of the last read.
- R10: fault_i has no effect unless a write is sampled. On a write, bit p of fault_i inverts stored codeword bit p (0..38).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | 32 | Write data |
| wpar_i | input | 4 | Host byte parity for wdata_i, even |
| fault_i | input | 39 | Codeword bits to invert on a write (defect model) |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, corrected |
| rpar_o | output | 4 | Regenerated byte parity, poisoned on double error |
| sec_o | output | 1 | Corrected single error on this read |
| ded_o | output | 1 | Uncorrectable double error on this read |
| sec_cnt_o | output | CNT_W (8) | Saturating corrected-read count |
| err_addr_o | output | ADDR_W (4) | Address of the last failing read |
| wpar_err_o | output | 1 | Sticky host write-parity mismatch |

## Verification
A single read completes three things at the same edge: the data is corrected, parity is rebuilt or poisoned, and the status log is updated, with the count possibly saturating. The bench provokes this overlap with reads of words that were written with one or two injected faults. A further run of repeated reads of one damaged word pushes the count past its limit. A behavioural model, built from the written words and the number of injected faults, predicts data, parity, flags, count and address for every cycle. All of these are compared at the falling edge.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CODE_W = DATA_W + HAM_W + 1;
  localparam int NBYTES = DATA_W / 8;

  // codeword index = Hamming position; index 0 holds overall parity
  function automatic bit is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] ecc_encode(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        c[p] = d[di];
        di++;
      end
    end
    for (int k = 0; k < HAM_W; k++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (!is_chk_pos(p) && ((p >> k) & 1) != 0) b = b ^ c[p];
      end
      c[1 << k] = b;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [HAM_W-1:0] ecc_syndrome(logic [CODE_W-1:0] c);
    logic [HAM_W-1:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (c[p]) s = s ^ HAM_W'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int di;
    d  = '0;
    di = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[di] = c[p];
        di++;
      end
    end
    return d;
  endfunction

  function automatic logic [NBYTES-1:0] byte_par(logic [DATA_W-1:0] d);
    logic [NBYTES-1:0] p;
    for (int b = 0; b < NBYTES; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb code_o = ecc_encode(data_i);
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);
  logic [HAM_W-1:0]  syn;
  logic              ovr;
  logic              fix_en;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    syn    = ecc_syndrome(code_i);
    ovr    = ^code_i;
    // odd overall parity with an in-range syndrome means one bit flipped
    fix_en = ovr && (int'(syn) < CODE_W);
    fixed  = code_i;
    for (int p = 0; p < CODE_W; p++) begin
      if (fix_en && int'(syn) == p) fixed[p] = ~code_i[p];
    end
    sec_o  = fix_en;
    ded_o  = (!ovr && syn != '0) || (ovr && !fix_en);
    data_o = ecc_extract(fixed);
  end
endmodule

// File: rtl/ecc_array.sv
module ecc_array
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CODE_W-1:0] wcode_i,
  input  logic [CODE_W-1:0] fault_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CODE_W-1:0] rcode_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CODE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wcode_i ^ fault_i;
    end
  end

  assign rcode_o = mem_q[raddr_i];
endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  logic              wr_fire_i,
  input  logic              sec_i,
  input  logic              ded_i,
  input  logic              wpar_bad_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CNT_W-1:0]  sec_cnt_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              wpar_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cnt_o  <= '0;
      err_addr_o <= '0;
      wpar_err_o <= 1'b0;
    end else begin
      if (rd_fire_i && sec_i && sec_cnt_o != CNT_MAX) sec_cnt_o <= sec_cnt_o + 1'b1;
      if (rd_fire_i && (sec_i || ded_i)) err_addr_o <= addr_i;
      if (wr_fire_i && wpar_bad_i) wpar_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_parity_module.sv
module ecc_parity_module
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wpar_i,
  input  logic [38:0]       fault_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  output logic [3:0]        rpar_o,
  output logic              sec_o,
  output logic              ded_o,
  output logic [CNT_W-1:0]  sec_cnt_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              wpar_err_o
);
  logic              wr_fire, rd_fire;
  logic [CODE_W-1:0] wcode, rcode;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sec, dec_ded;
  logic [NBYTES-1:0] wpar_calc, rpar_calc, rpar_next;

  assign wr_fire = req_i && we_i;
  assign rd_fire = req_i && !we_i;

  // host-side parity: check on write, regenerate on read
  for (genvar b = 0; b < NBYTES; b++) begin : g_par
    assign wpar_calc[b] = ^wdata_i[8*b +: 8];
    assign rpar_calc[b] = ^dec_data[8*b +: 8];
    assign rpar_next[b] = rpar_calc[b] ^ dec_ded;
  end

  ecc_enc i_enc (
    .data_i (wdata_i),
    .code_o (wcode)
  );

  ecc_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_fire),
    .waddr_i (addr_i),
    .wcode_i (wcode),
    .fault_i (fault_i),
    .raddr_i (addr_i),
    .rcode_o (rcode)
  );

  ecc_dec i_dec (
    .code_i (rcode),
    .data_o (dec_data),
    .sec_o  (dec_sec),
    .ded_o  (dec_ded)
  );

  err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_fire_i  (rd_fire),
    .wr_fire_i  (wr_fire),
    .sec_i      (dec_sec),
    .ded_i      (dec_ded),
    .wpar_bad_i (wpar_calc != wpar_i),
    .addr_i     (addr_i),
    .sec_cnt_o  (sec_cnt_o),
    .err_addr_o (err_addr_o),
    .wpar_err_o (wpar_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      sec_o    <= 1'b0;
      ded_o    <= 1'b0;
      rdata_o  <= '0;
      rpar_o   <= '0;
    end else begin
      rvalid_o <= rd_fire;
      sec_o    <= rd_fire && dec_sec;
      ded_o    <= rd_fire && dec_ded;
      if (rd_fire) begin
        rdata_o <= dec_data;
        rpar_o  <= rpar_next;
      end
    end
  end
endmodule

// File: rtl/ecc_parity_module_chk.sv
module ecc_parity_module_chk
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             rvalid_o,
  input logic [31:0]      rdata_o,
  input logic [3:0]       rpar_o,
  input logic             sec_o,
  input logic             ded_o,
  input logic [CNT_W-1:0] sec_cnt_o,
  input logic             wpar_err_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  // R1
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  // R2
  par_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !ded_o) |-> (rpar_o == byte_par(rdata_o)));

  // R6
  par_poison_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ded_o |-> (rpar_o == ~byte_par(rdata_o)));

  // R3
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_o && ded_o));

  // R3
  flag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o || ded_o) |-> rvalid_o);

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |-> ((sec_cnt_o == CNT_W'($past(sec_cnt_o) + 1'b1)) ||
               ($past(sec_cnt_o) == CNT_TOP && sec_cnt_o == CNT_TOP)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_o |-> $stable(sec_cnt_o));

  // R7
  wperr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wpar_err_o) |-> wpar_err_o);
endmodule

bind ecc_parity_module ecc_parity_module_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_ecc_parity_module.sv
`timescale 1ns/1ps
module test_ecc_parity_module;
  localparam int AW = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    wpar = '0;
  logic [38:0]   fault = '0;
  logic          rvalid, sec, ded, wperr;
  logic [31:0]   rdata;
  logic [3:0]    rpar;
  logic [CW-1:0] cnt;
  logic [AW-1:0] eaddr;

  int errors = 0;
  int checks = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_parity_module #(.ADDR_W(AW), .CNT_W(CW)) i_ecc_parity_module (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .wpar_i(wpar), .fault_i(fault), .rvalid_o(rvalid),
    .rdata_o(rdata), .rpar_o(rpar), .sec_o(sec), .ded_o(ded),
    .sec_cnt_o(cnt), .err_addr_o(eaddr), .wpar_err_o(wperr)
  );

  function automatic logic [3:0] epar(logic [31:0] d);
    logic [3:0] p;
    p = '0;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++) p[b] = p[b] ^ d[8*b + i];
    return p;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [31:0] m_data [16];
  int          m_flt  [16];
  bit          x_rvalid, x_sec, x_ded, x_last_ded, x_wperr;
  logic [31:0] x_data;
  int          x_cnt;
  logic [AW-1:0] x_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_data[i] = '0; m_flt[i] = 0; end
      x_rvalid = 0; x_sec = 0; x_ded = 0; x_last_ded = 0; x_wperr = 0;
      x_data = '0; x_cnt = 0; x_addr = '0;
    end else begin
      x_rvalid = 0; x_sec = 0; x_ded = 0;
      if (req && we) begin
        m_data[addr] = wdata;
        m_flt[addr]  = $countones(fault);
        if (wpar != epar(wdata)) x_wperr = 1;
      end else if (req) begin
        x_rvalid   = 1;
        x_data     = m_data[addr];
        x_sec      = (m_flt[addr] == 1);
        x_ded      = (m_flt[addr] == 2);
        x_last_ded = x_ded;
        if (x_sec && x_cnt < 255) x_cnt++;
        if (x_sec || x_ded) x_addr = addr;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(rvalid == x_rvalid, "R1", "rvalid", 64'(rvalid), 64'(x_rvalid));
      chk(sec == x_sec, "R3", "sec", 64'(sec), 64'(x_sec));
      chk(ded == x_ded, "R6", "ded", 64'(ded), 64'(x_ded));
      chk(int'(cnt) == x_cnt, "R4", "sec_cnt", 64'(cnt), 64'(x_cnt));
      chk(eaddr == x_addr, "R5", "err_addr", 64'(eaddr), 64'(x_addr));
      chk(wperr == x_wperr, "R7", "wpar_err", 64'(wperr), 64'(x_wperr));
      if (!x_last_ded) begin
        // R9 holds these between reads
        chk(rdata == x_data, "R1", "rdata", 64'(rdata), 64'(x_data));
        chk(rpar == epar(x_data), "R2", "rpar", 64'(rpar), 64'(epar(x_data)));
      end else begin
        chk(rpar == ~epar(rdata), "R6", "poisoned rpar", 64'(rpar), 64'(~epar(rdata)));
      end
    end
  end

  task automatic op(bit r, bit w, int a, logic [31:0] d, logic [3:0] badp, logic [38:0] f);
    req = r; we = w; addr = AW'(a); wdata = d; wpar = epar(d) ^ badp; fault = f;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d, logic [38:0] f, logic [3:0] badp);
    op(1, 1, a, d, badp, f);
  endtask

  task automatic rd(int a, logic [38:0] f);
    op(1, 0, a, 32'h0, 4'h0, f);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 32'h0, 4'h0, '0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired @%0t", $time);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state at the ports
    chk({rvalid, sec, ded, wperr} == 4'b0, "R8", "flags after reset", 64'({rvalid, sec, ded, wperr}), 64'h0);
    chk(rdata == 32'h0 && rpar == 4'h0, "R8", "data after reset", 64'({rdata, rpar}), 64'h0);
    chk(cnt == '0 && eaddr == '0, "R8", "status after reset", 64'({cnt, eaddr}), 64'h0);
    cmp_en = 1'b1;
    rd(3, '0);                         // R8 unwritten word reads zero
    idle(1);
    // R1 R2 plain patterns
    for (int a = 0; a < 16; a++) wr(a, 32'h0101_0101 * a ^ 32'hA5C3_0F96, '0, 4'h0);
    for (int a = 0; a < 16; a++) rd(a, '0);
    wr(4, 32'hFFFF_FFFF, '0, 4'h0); rd(4, '0);
    wr(4, 32'h0000_0000, '0, 4'h0); rd(4, '0);
    idle(3);                           // R9 hold
    // R3 R4 R5 single fault at every codeword position
    for (int p = 0; p < 39; p++) begin
      wr(5, 32'h8000_0001 ^ (32'h1 << (p % 32)), 39'h1 << p, 4'h0);
      rd(5, '0);
    end
    // R7 bad host parity, data still stored
    wr(6, 32'h1234_5678, '0, 4'b0010);
    rd(6, '0);
    idle(2);
    // R6 double faults
    wr(7, 32'hDEAD_BEEF, 39'h3, 4'h0);       rd(7, '0);
    wr(8, 32'h0F0F_F0F0, 39'h11 << 20, 4'h0); rd(8, '0);
    wr(8, 32'h0F0F_F0F0, 39'h1 | (39'h1 << 38), 4'h0); rd(8, '0);
    // R10 fault_i ignored on reads and idles
    rd(6, 39'h5);
    op(0, 0, 6, 32'h0, 4'h0, 39'h7F);
    rd(6, '0);
    // random traffic
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr(int'(lfsr[3:0]), lfsr * 32'h9E37_79B9, '0, 4'h0);
      rd(int'(lfsr[3:0]), '0);
    end
    // R4 saturation: one damaged word read many times
    wr(9, 32'hCAFE_F00D, 39'h1 << 17, 4'h0);
    for (int i = 0; i < 240; i++) rd(9, '0);
    rd(2, '0);
    idle(2);
    chk(cnt == 8'd255, "R4", "saturated count", 64'(cnt), 64'd255);
    chk(eaddr == 4'd9, "R5", "last failing address", 64'(eaddr), 64'd9);
    finish_run();
  end
endmodule